// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block models the digital timing logic that sits behind a linear photodiode array, split into sections of `NPIX` pixels each. For each section it produces a one-hot pixel select and a global integrator-reset window. It also produces a per-pixel flag telling whether that pixel's sample capacitor is connected to its integrator. An output-enable flag stands for the analog output being driven rather than floating. A serial-out pulse marks the last pixel and can start the next section. Light, charge and voltages are not modelled; only the switch-control timing is.

A scan begins when a section samples its start input high on a rising clock edge. A rising edge on the hold input freezes every sampler at once and opens the integrator-reset window. Start and hold are normally driven together. The `serial_mode` input selects how the sections are joined. When it is high, each section after the first takes its start from the previous section's serial-out and its hold from section 0, so the sections read out back to back. When it is low, every section uses its own start and hold.

Top module: `lss_top`

## Requirements
- R1: After synchronous reset, all selects are 0, and out-enable, serial-out, integrator reset and violation are 0. Every sampler flag is 1 (connected).
- R2: A section that samples start high on an edge selects pixel 1 after that edge and raises out-enable. Each later edge moves the selection up one pixel. Pixel p of section s is bit s*NPIX+(p-1) of `sel_o` and `smp_conn_o`.
- R3: Serial-out is high only after the NPIX-th edge of a scan, counting the start edge as the first. On the next edge (NPIX+1), serial-out, the select and out-enable all drop.
- R4: A rising edge on a section's effective hold input clears all of that section's sampler flags and raises its integrator reset, both visible after that edge.
- R5: The integrator reset stays high for RST_CLKS cycles, from the start edge through the next RST_CLKS-1 edges. It drops on edge RST_CLKS+1.
- R6: Pixel p has its sampler flag set again on edge max(p+1, RST_CLKS+1) after the scan's start edge. Pixels read during the reset window therefore all reconnect together when the window closes.
- R7: With `serial_mode`=1, section s>0 starts from the serial-out of section s-1 and takes its hold from `hold_i[0]`. Its own `start_i`/`hold_i` bits have no effect. Two sections finish after 2*NPIX+1 edges.
- R8: With `serial_mode`=0, each section runs from its own start and hold, and each finishes after NPIX+1 edges.
- R9: A start sampled while out-enable is high restarts the scan at pixel 1. It also raises `viol_o` for exactly one cycle.
- R10: Within a section, at most one select bit is high, and out-enable equals the OR of that section's select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| serial_mode | input | 1 | 1 chains the sections, 0 runs them independently |
| start_i | input | NSEC | Per-section scan start pulse |
| hold_i | input | NSEC | Per-section hold, rising edge active |
| sel_o | output | NSEC*NPIX | One-hot pixel select per section |
| smp_conn_o | output | NSEC*NPIX | 1 = sample capacitor connected to integrator |
| intg_rst_o | output | NSEC | Global integrator reset per section |
| out_en_o | output | NSEC | Output driven (low means high impedance) |
| so_o | output | NSEC | Serial-out pulse on the last pixel |
| viol_o | output | NSEC | One-cycle flag for a start during an active scan |

## Verification
The bench compares every output bit against arithmetic expectations on each cycle of whole scans, in both chaining modes. The sharpest corner is the group of pixels read inside the reset window. A design that reconnects them one by one, as it does later pixels, or that reconnects pixel RST_CLKS one edge early, shows a sampler flag rising before edge RST_CLKS+1. The hand-over between sections is the other target. An off-by-one in the serial-out stage shifts every pixel of the second section by one edge, and a missing final clock leaves out-enable high after the last pixel. A restart in mid-scan is injected as well. A design that ignores it, or fails to reopen the samplers, keeps scanning from the old position with no violation flag.

// File: rtl/lss_pkg.sv
package lss_pkg;
  // Width needed to hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/lss_rstwin.sv
module lss_rstwin #(
  parameter int unsigned RST_CLKS = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic hold_edge_o,
  output logic rst_next_o,
  output logic intg_rst_o
);
  localparam int unsigned CW = lss_pkg::cnt_w(RST_CLKS);

  logic          hold_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;

  assign hold_edge_o = hold_i & ~hold_q;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (hold_edge_o) begin
      act_n = 1'b1;
      cnt_n = CW'(RST_CLKS - 1);
    end else if (act_q && cnt_q == '0) begin
      act_n = 1'b0;
    end else if (act_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_i;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
    end
  end

  assign rst_next_o = act_n;
  assign intg_rst_o = act_q;
endmodule

// File: rtl/lss_cell.sv
module lss_cell (
  input  logic clk,
  input  logic rst,
  input  logic hold_edge_i,
  input  logic rst_next_i,
  input  logic leave_i,
  output logic conn_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_o <= 1'b1;
      pend_q <= 1'b0;
    end else if (hold_edge_i) begin
      conn_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      conn_o <= conn_o | ((leave_i | pend_q) & ~rst_next_i);
      pend_q <= (pend_q | leave_i) & rst_next_i;
    end
  end
endmodule

// File: rtl/lss_section.sv
module lss_section #(
  parameter int unsigned NPIX     = 640,
  parameter int unsigned RST_CLKS = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            hold_i,
  output logic [NPIX-1:0] sel_o,
  output logic [NPIX-1:0] conn_o,
  output logic            intg_rst_o,
  output logic            out_en_o,
  output logic            so_o,
  output logic            viol_o
);
  logic [NPIX-1:0] sr_n;
  logic            hold_edge, rst_next;

  lss_rstwin #(.RST_CLKS(RST_CLKS)) u_win (
    .clk(clk), .rst(rst), .hold_i(hold_i),
    .hold_edge_o(hold_edge), .rst_next_o(rst_next), .intg_rst_o(intg_rst_o)
  );

  assign sr_n = start_i ? NPIX'(1) : {sel_o[NPIX-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o    <= '0;
      out_en_o <= 1'b0;
      viol_o   <= 1'b0;
    end else begin
      sel_o    <= sr_n;
      out_en_o <= |sr_n;
      viol_o   <= start_i & out_en_o;
    end
  end

  assign so_o = sel_o[NPIX-1];

  for (genvar i = 0; i < NPIX; i++) begin : g_cell
    lss_cell u_cell (
      .clk(clk), .rst(rst), .hold_edge_i(hold_edge), .rst_next_i(rst_next),
      .leave_i(sel_o[i]), .conn_o(conn_o[i])
    );
  end
endmodule

// File: rtl/lss_top.sv
module lss_top #(
  parameter int unsigned NSEC     = 2,
  parameter int unsigned NPIX     = 640,
  parameter int unsigned RST_CLKS = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serial_mode,
  input  logic [NSEC-1:0]      start_i,
  input  logic [NSEC-1:0]      hold_i,
  output logic [NSEC*NPIX-1:0] sel_o,
  output logic [NSEC*NPIX-1:0] smp_conn_o,
  output logic [NSEC-1:0]      intg_rst_o,
  output logic [NSEC-1:0]      out_en_o,
  output logic [NSEC-1:0]      so_o,
  output logic [NSEC-1:0]      viol_o
);
  logic [NSEC-1:0] st, hd;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    if (s == 0) begin : g_head
      assign st[s] = start_i[s];
      assign hd[s] = hold_i[s];
    end else begin : g_tail
      assign st[s] = serial_mode ? so_o[s-1] : start_i[s];
      assign hd[s] = serial_mode ? hold_i[0] : hold_i[s];
    end
    lss_section #(.NPIX(NPIX), .RST_CLKS(RST_CLKS)) u_sec (
      .clk(clk), .rst(rst), .start_i(st[s]), .hold_i(hd[s]),
      .sel_o(sel_o[s*NPIX +: NPIX]), .conn_o(smp_conn_o[s*NPIX +: NPIX]),
      .intg_rst_o(intg_rst_o[s]), .out_en_o(out_en_o[s]),
      .so_o(so_o[s]), .viol_o(viol_o[s])
    );
  end
endmodule

// File: rtl/lss_chk.sv
module lss_chk #(
  parameter int unsigned NSEC     = 2,
  parameter int unsigned NPIX     = 640,
  parameter int unsigned RST_CLKS = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NSEC-1:0]      hd,
  input logic [NSEC*NPIX-1:0] sel_o,
  input logic [NSEC*NPIX-1:0] smp_conn_o,
  input logic [NSEC-1:0]      intg_rst_o,
  input logic [NSEC-1:0]      out_en_o,
  input logic [NSEC-1:0]      so_o,
  input logic [NSEC-1:0]      viol_o
);
  localparam int unsigned CW = lss_pkg::cnt_w(RST_CLKS + 1);

  for (genvar s = 0; s < NSEC; s++) begin : g_c
    logic          hq;
    logic [CW-1:0] run;
    always_ff @(posedge clk) begin
      if (rst) begin
        hq  <= 1'b0;
        run <= '0;
      end else begin
        hq <= hd[s];
        if (hd[s] && !hq) run <= '0;
        else if (intg_rst_o[s] && run != CW'(RST_CLKS + 1)) run <= run + 1'b1;
      end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_o[s*NPIX +: NPIX])); // R10
    AST_OE_TRACKS_SEL: assert property (@(posedge clk) disable iff (rst)
      out_en_o[s] == (|sel_o[s*NPIX +: NPIX])); // R10
    AST_SO_ON_LAST: assert property (@(posedge clk) disable iff (rst)
      so_o[s] |=> !so_o[s] && !out_en_o[s] || sel_o[s*NPIX]); // R3
    AST_HOLD_OPENS: assert property (@(posedge clk) disable iff (rst)
      (hd[s] && !hq) |=> intg_rst_o[s] && smp_conn_o[s*NPIX +: NPIX] == '0); // R4
    AST_WIN_LEN: assert property (@(posedge clk) disable iff (rst)
      $fell(intg_rst_o[s]) |-> run == CW'(RST_CLKS)); // R5
    AST_VIOL_RESTART: assert property (@(posedge clk) disable iff (rst)
      viol_o[s] |-> sel_o[s*NPIX]); // R9
  end
endmodule

bind lss_top lss_chk #(.NSEC(NSEC), .NPIX(NPIX), .RST_CLKS(RST_CLKS)) u_chk (
  .clk(clk), .rst(rst), .hd(hd), .sel_o(sel_o), .smp_conn_o(smp_conn_o),
  .intg_rst_o(intg_rst_o), .out_en_o(out_en_o), .so_o(so_o), .viol_o(viol_o)
);

// File: tb/sim_lss_top.sv
module sim_lss_top;
  localparam int NSEC = 2;
  localparam int NPIX = 32;
  localparam int RSTC = 18;

  logic clk = 1'b0, rst = 1'b1, serial_mode = 1'b1;
  logic [NSEC-1:0] start_i = '0, hold_i = '0;
  logic [NSEC*NPIX-1:0] sel_o, smp_conn_o;
  logic [NSEC-1:0] intg_rst_o, out_en_o, so_o, viol_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lss_top #(.NSEC(NSEC), .NPIX(NPIX), .RST_CLKS(RSTC)) u0 (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .start_i(start_i),
    .hold_i(hold_i), .sel_o(sel_o), .smp_conn_o(smp_conn_o),
    .intg_rst_o(intg_rst_o), .out_en_o(out_en_o), .so_o(so_o), .viol_o(viol_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected outputs k edges after the scan's start edge (k>=1)
  task automatic check_k(input int k, input bit serial, input bit vfirst);
    for (int s = 0; s < NSEC; s++) begin
      int off;
      logic [NPIX-1:0] esel, econn;
      off = serial ? s * NPIX : 0;
      for (int p = 1; p <= NPIX; p++) begin
        int rc;
        rc = (off + p + 1 > RSTC + 1) ? off + p + 1 : RSTC + 1;
        esel[p-1]  = (k == off + p);
        econn[p-1] = (k >= rc);
      end
      chk(sel_o[s*NPIX +: NPIX] == esel, "R2 select",
          longint'(sel_o[s*NPIX +: NPIX]), longint'(esel));
      chk(smp_conn_o[s*NPIX +: NPIX] == econn, "R6 sampler",
          longint'(smp_conn_o[s*NPIX +: NPIX]), longint'(econn));
      chk(out_en_o[s] == (k >= off + 1 && k <= off + NPIX), "R3 out_en",
          longint'(out_en_o[s]), longint'(k >= off + 1 && k <= off + NPIX));
      chk(so_o[s] == (k == off + NPIX), "R3 so",
          longint'(so_o[s]), longint'(k == off + NPIX));
      chk(intg_rst_o[s] == (k >= 1 && k <= RSTC), "R5 intg_rst",
          longint'(intg_rst_o[s]), longint'(k >= 1 && k <= RSTC));
      chk(viol_o[s] == (vfirst && s == 0 && k == 1), "R9 viol",
          longint'(viol_o[s]), longint'(vfirst && s == 0 && k == 1));
      if (k == 1)
        chk(smp_conn_o[s*NPIX +: NPIX] == '0, "R4 hold opens",
            longint'(smp_conn_o[s*NPIX +: NPIX]), 0);
    end
  endtask

  // Called at a negedge; pulses start/hold and checks ncyc edges
  task automatic do_scan(input bit serial, input int ncyc, input bit vfirst);
    serial_mode = serial;
    // R7: in serial mode start_i[1]/hold_i[1] are driven too and must be ignored
    start_i = '1;
    hold_i  = serial ? 2'b01 : '1;
    if (serial) hold_i[1] = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk);
      @(negedge clk);
      start_i = '0;
      hold_i  = '0;
      check_k(k, serial, vfirst);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sel_o == '0, "R1 sel", longint'(sel_o), 0);
    chk(smp_conn_o == '1, "R1 conn", longint'(smp_conn_o[63:0]), -1);
    chk({intg_rst_o, out_en_o, so_o, viol_o} == '0, "R1 flags",
        longint'({intg_rst_o, out_en_o, so_o, viol_o}), 0);
    // R7 serial chain, full 2*NPIX+1 edges plus idle tail
    do_scan(1'b1, 2 * NPIX + 3, 1'b0);
    repeat (4) @(negedge clk);
    // R8 parallel sections
    do_scan(1'b0, NPIX + 3, 1'b0);
    repeat (2) @(negedge clk);
    // R9 restart in mid-scan
    do_scan(1'b1, 9, 1'b0);
    do_scan(1'b1, 2 * NPIX + 3, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule